// File: doc/BRIEF.md
# PUF Challenge Pair Sequencer

This block walks a ring-oscillator PUF bit controller through a fixed set of 128 challenges and gathers the answers into one 128-bit device response. A single-cycle start in idle clears the response register and launches the run. For each challenge the block presents a pair of 0-based oscillator indexes with a one-cycle request strobe. It then waits for the bit controller's bit-done handshake and takes the returned bit into the response.

The challenge set has two families over a bank of 64 oscillators. In the first family each oscillator is paired with the next one up. In the second family it is paired with the oscillator four places up. Both families wrap modulo 64. After the last bit the block gives a one-cycle done pulse. The full response then stays unchanged until the next start.

Top module: `puf_pair_seq`

## Requirements
- R1: After reset, busy_o, done_o and req_o are 0 and resp_o is all zeros.
- R2: A start_i seen while idle makes busy_o 1 on the next cycle and clears resp_o to zero. It also raises req_o in that same next cycle with the first pair, idx_a_o=0 and idx_b_o=1.
- R3: For 0-based challenge c in 0..63, the pair issued is idx_a_o=c and idx_b_o=(c+1) mod 64.
- R4: For 0-based challenge c in 64..127, the pair issued is idx_a_o=c-64 and idx_b_o=(c-64+4) mod 64.
- R5: req_o is high for exactly one cycle per challenge. The next request comes only in the cycle after a bit_done_i accepted for the current one. bit_done_i is accepted only from the cycle after the request onwards, and req_o stays low while the block waits.
- R6: bit_i, sampled with the bit_done_i of challenge c (0-based), ends up at resp_o[c], so challenge t (1-based) lands at bit t-1.
- R7: The cycle after the 128th accepted bit_done_i, done_o is 1 for one cycle, busy_o is 0, and resp_o holds the complete response.
- R8: While idle, resp_o does not change until a start_i arrives, and bit_done_i pulses have no effect on it.
- R9: start_i is ignored while busy: the pair sequence and the response continue unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, acted on only when idle |
| busy_o | output | 1 | High from the cycle after start until the run ends |
| done_o | output | 1 | One-cycle pulse when the response is complete |
| req_o | output | 1 | One-cycle request strobe toward the bit controller |
| idx_a_o | output | 6 | First oscillator index, 0-based |
| idx_b_o | output | 6 | Second oscillator index, 0-based |
| bit_i | input | 1 | Response bit from the bit controller |
| bit_done_i | input | 1 | Bit-done handshake from the bit controller |
| resp_o | output | 128 | Assembled response |

## Verification
A wrong challenge counter shows up at once as an unexpected index pair in the next request. It also moves the done pulse away from the 128th handshake. A fault in the state sequence shows as a request repeated, missing or issued during the wait, within one cycle of the handshake. Shift-order or clear faults appear only at completion, as a response that differs from the expected one at specific bit positions. They can also appear one cycle after start as a response that is not zero.

// File: rtl/puf_seq_pkg.sv
package puf_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/puf_pair_gen.sv
module puf_pair_gen #(
  parameter int IDX_W = 6,
  parameter int OFF_A = 1,
  parameter int OFF_B = 4,
  localparam int CNT_W = IDX_W + 1
) (
  input  logic [CNT_W-1:0] chal_i,
  output logic [IDX_W-1:0] idx_a_o,
  output logic [IDX_W-1:0] idx_b_o
);
  localparam logic [IDX_W-1:0] OffA = IDX_W'(OFF_A);
  localparam logic [IDX_W-1:0] OffB = IDX_W'(OFF_B);

  logic             fam_hi;
  logic [IDX_W-1:0] base;

  assign fam_hi  = chal_i[CNT_W-1];
  assign base    = chal_i[IDX_W-1:0];
  assign idx_a_o = base;
  // natural wrap of the IDX_W-bit sum gives modulo bank size
  assign idx_b_o = base + (fam_hi ? OffB : OffA);
endmodule

// File: rtl/puf_resp_shreg.sv
module puf_resp_shreg #(
  parameter int N = 128
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         shift_i,
  input  logic         bit_i,
  output logic [N-1:0] resp_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      resp_o <= '0;
    else if (clr_i)   resp_o <= '0;
    else if (shift_i) resp_o <= {bit_i, resp_o[N-1:1]};  // first bit drifts to LSB
  end

  a_r8_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !shift_i) |=> $stable(resp_o));
endmodule

// File: rtl/puf_seq_ctrl.sv
module puf_seq_ctrl
  import puf_seq_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             bit_done_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             req_o,
  output logic [CNT_W-1:0] chal_o,
  output logic             clr_o,
  output logic             shift_o
);
  seq_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             done_q;
  logic             last;

  assign last    = (cnt_q == '1);
  assign busy_o  = (state_q != ST_IDLE);
  assign req_o   = (state_q == ST_ISSUE);
  assign done_o  = done_q;
  assign chal_o  = cnt_q;
  assign clr_o   = (state_q == ST_IDLE) && start_i;
  assign shift_o = (state_q == ST_WAIT) && bit_done_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_ISSUE;
          cnt_q   <= '0;
        end
        ST_ISSUE: state_q <= ST_WAIT;
        ST_WAIT: if (bit_done_i) begin
          if (last) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end else begin
            state_q <= ST_ISSUE;
            cnt_q   <= cnt_q + CNT_W'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  a_r5_req_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |=> !req_o);
  a_r7_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r7_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  a_r5_no_req_waiting: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !req_o && !bit_done_i) |=> !req_o);
endmodule

// File: rtl/puf_pair_seq.sv
module puf_pair_seq #(
  parameter int IDX_W = 6,
  parameter int OFF_A = 1,
  parameter int OFF_B = 4,
  localparam int NUM_RO = 1 << IDX_W,
  localparam int NUM_CH = 2 * NUM_RO,
  localparam int CNT_W  = IDX_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              req_o,
  output logic [IDX_W-1:0]  idx_a_o,
  output logic [IDX_W-1:0]  idx_b_o,
  input  logic              bit_i,
  input  logic              bit_done_i,
  output logic [NUM_CH-1:0] resp_o
);
  logic [CNT_W-1:0] chal;
  logic             clr;
  logic             shift;

  puf_seq_ctrl #(.CNT_W(CNT_W)) i_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .bit_done_i (bit_done_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .req_o      (req_o),
    .chal_o     (chal),
    .clr_o      (clr),
    .shift_o    (shift)
  );

  puf_pair_gen #(.IDX_W(IDX_W), .OFF_A(OFF_A), .OFF_B(OFF_B)) i_gen (
    .chal_i  (chal),
    .idx_a_o (idx_a_o),
    .idx_b_o (idx_b_o)
  );

  puf_resp_shreg #(.N(NUM_CH)) i_resp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr),
    .shift_i (shift),
    .bit_i   (bit_i),
    .resp_o  (resp_o)
  );

  a_r2_first_pair: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> (req_o && idx_a_o == '0 && idx_b_o == IDX_W'(OFF_A) && resp_o == '0));
endmodule

// File: tb/test_puf_pair_seq.sv
module test_puf_pair_seq;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WD_LIMIT   = 100000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic         bit_in = 1'b0;
  logic         bit_done = 1'b0;
  logic         busy, done, req;
  logic [5:0]   idx_a, idx_b;
  logic [127:0] resp;

  int total = 0;
  int bad   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  puf_pair_seq i_puf_pair_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .busy_o(busy), .done_o(done),
    .req_o(req), .idx_a_o(idx_a), .idx_b_o(idx_b), .bit_i(bit_in),
    .bit_done_i(bit_done), .resp_o(resp)
  );

  task automatic chk(input bit ok, input string rq, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", rq, act, exp);
    end
  endtask

  function automatic logic [5:0] exp_a(input int c);
    return 6'((c < 64) ? c : c - 64);
  endfunction

  function automatic logic [5:0] exp_b(input int c);
    return 6'((c < 64) ? (c + 1) % 64 : (c - 64 + 4) % 64);
  endfunction

  function automatic bit gen_bit(input int mode, input int c);
    case (mode)
      1: return 1'b1;
      2: return 1'b0;
      3: return c[0];
      default: return 1'($urandom());
    endcase
  endfunction

  task automatic run_one(input int mode, input bit poke_start);
    logic [127:0] exp_resp = '0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1, "R2 busy", 128'(busy), 128'd1);
    chk(resp === '0, "R2 clear", resp, '0);
    for (int c = 0; c < 128; c++) begin
      bit b = gen_bit(mode, c);
      int extra = $urandom_range(0, 2);
      chk(req === 1'b1, (c == 0) ? "R2 req" : "R5 req", 128'(req), 128'd1);
      chk(idx_a === exp_a(c), (c < 64) ? "R3 idx_a" : "R4 idx_a", 128'(idx_a), 128'(exp_a(c)));
      chk(idx_b === exp_b(c), (c < 64) ? "R3 idx_b" : "R4 idx_b", 128'(idx_b), 128'(exp_b(c)));
      exp_resp[c] = b;
      @(negedge clk);
      chk(req === 1'b0, "R5 pulse", 128'(req), 128'd0);
      if (poke_start && c == 5) begin
        start = 1'b1;  // R9: ignored while busy
        @(negedge clk);
        start = 1'b0;
        chk(req === 1'b0 && busy === 1'b1, "R9 start busy", 128'({busy, req}), 128'b10);
      end
      for (int e = 0; e < extra; e++) begin
        @(negedge clk);
        chk(req === 1'b0, "R5 wait", 128'(req), 128'd0);
      end
      bit_done = 1'b1;
      bit_in   = b;
      @(negedge clk);
      bit_done = 1'b0;
      bit_in   = 1'b0;
      if (c < 127) chk(done === 1'b0, "R7 early done", 128'(done), 128'd0);
    end
    chk(done === 1'b1 && busy === 1'b0, "R7 done", 128'({done, busy}), 128'b10);
    chk(resp === exp_resp, "R6 response", resp, exp_resp);
    @(negedge clk);
    chk(done === 1'b0, "R7 done pulse", 128'(done), 128'd0);
    for (int k = 0; k < 3; k++) begin
      bit_done = 1'b1;
      bit_in   = ~exp_resp[k];
      @(negedge clk);
      bit_done = 1'b0;
      @(negedge clk);
      chk(resp === exp_resp && req === 1'b0, "R8 idle hold", resp, exp_resp);
    end
  endtask

  initial begin
    int cyc = 0;
    while (cyc < WD_LIMIT) begin
      @(posedge clk);
      cyc++;
    end
    bad++;
    total++;
    $display("FAIL watchdog act=%0d exp=<%0d", cyc, WD_LIMIT);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0 && req === 1'b0, "R1 outputs",
        128'({busy, done, req}), 128'd0);
    chk(resp === '0, "R1 resp", resp, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy === 1'b0 && req === 1'b0, "R1 after release", 128'({busy, req}), 128'd0);
    bit_done = 1'b1;
    bit_in   = 1'b1;
    @(negedge clk);
    bit_done = 1'b0;
    @(negedge clk);
    chk(resp === '0 && busy === 1'b0, "R8 idle bit_done", resp, '0);
    run_one(1, 1'b0);
    run_one(3, 1'b1);
    run_one(0, 1'b0);
    run_one(2, 1'b0);
    run_one(0, 1'b1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule